// File: doc/BRIEF.md
# Address-Latched Write-Once Byte Memory

This block models a byte-wide memory whose cells can be cleared but never set again, with an address latch built in. The latch lets a processor with a shared address/data bus connect without a separate latch: while the strobe input is high the address passes straight through, and while it is low the last address is held. All inputs are sampled on one system clock. Two active-low enables and a program-supply flag select the operating mode, and the block either drives a stored byte, drives a two-byte identifier, or leaves the data bus undriven.

Writing is done with the program-supply flag raised and output enable high. The chip enable is pulsed low, and the write is committed on the clock where chip enable is first seen high again. The stored byte becomes the old byte ANDed with the data on the input bus, so a write can only clear bits. A separate high-voltage flag for address bit 9 selects an identifier mode. This mode returns a maker code or a part code, picked by the live address bit 0, whatever the state of the strobe.

The port address is always 15 bits wide. The number of cells actually implemented is set by `STORE_AW`, and addresses alias on their low `STORE_AW` bits. A full-size instance sets `STORE_AW` to 15.

Top module: `otp_latched_rom`

## Requirements
- R1: After reset every cell reads 0xFF, and in standby the data output is not driven (`doe_o`=0, `dout_o`=0).
- R2: The effective address follows `addr_i` in the same cycle while `strb_i` or `vpp_i` is 1. While both are 0 it holds the value it had on the last clock edge, whatever `addr_i` does.
- R3: With `vpp_i`=0, `id_hv_i`=0, `ce_n_i`=0 and `oe_n_i`=0, the block drives the byte stored at the effective address, with `doe_o`=1.
- R4: With `vpp_i`=0 the data bus is undriven when `ce_n_i`=1, whatever `oe_n_i` is, and also when `ce_n_i`=0 with `oe_n_i`=1. Whenever `doe_o`=0, `dout_o` is 0.
- R5: A write happens on a clock edge where `ce_n_i` is 1 and was 0 at the previous edge, with `vpp_i`=1 and `oe_n_i`=1. The cell at `addr_i` becomes its old value AND `din_i`.
- R6: A rising chip enable with `vpp_i`=0, or with `oe_n_i`=0, changes no cell.
- R7: With `vpp_i`=1, `ce_n_i`=1 and `oe_n_i`=0, the block drives the byte stored at `addr_i`, with `doe_o`=1.
- R8: With `vpp_i`=1 and both enables at the same level, the data bus is undriven.
- R9: With `id_hv_i`=1, `vpp_i`=0 and both enables low, the output is 0x20 when `addr_i[0]`=0 and 0x80 when `addr_i[0]`=1, whatever `strb_i` is.
- R10: Addresses that differ only above bit `STORE_AW`-1 reach the same cell. The default `STORE_AW` is 11.
- R11: A bit that reads 0 at an address never reads 1 again at that address until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset; also erases all cells to ones |
| addr_i | input | 15 | Address bus |
| din_i | input | 8 | Data to be written |
| dout_o | output | 8 | Data out, zero when not driven |
| doe_o | output | 1 | Data bus drive enable |
| ce_n_i | input | 1 | Chip enable, active low; its rising edge commits a write |
| oe_n_i | input | 1 | Output enable, active low |
| strb_i | input | 1 | Address strobe: 1 passes the address through, 0 holds it |
| vpp_i | input | 1 | Program-supply flag; forces the strobe high |
| id_hv_i | input | 1 | Identifier request (high voltage on address bit 9) |

## Verification
The assertions check on every cycle that no drive occurs in standby, output-disable or inhibit, that an undriven bus reads zero, and that the held address stays frozen while the strobe is low. They also check that the identifier codes follow bit 0 and that repeated verify reads of one address never gain a bit. Whether a write lands on the right cell with AND semantics, whether rising enables without the supply flag or with output enable low leave cells untouched, and whether aliasing holds can only be shown by the bench. It does this through program, verify and read sequences compared with its own model of the array.

// File: rtl/olr_pkg.sv
package olr_pkg;
   typedef enum logic [2:0] {
      MD_STANDBY,
      MD_READ,
      MD_IDENT,
      MD_OUT_OFF,
      MD_PROGRAM,
      MD_VERIFY,
      MD_INHIBIT
   } olr_mode_e;

   localparam logic [7:0] ID_MAKER = 8'h20;
   localparam logic [7:0] ID_PART  = 8'h80;
endpackage

// File: rtl/olr_addr_latch.sv
module olr_addr_latch #(
   parameter int W = 15
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         pass,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   logic [W-1:0] held;

   for (genvar b = 0; b < W; b++) begin : g_bit
      assign q[b] = pass ? d[b] : held[b];
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) held[b] <= 1'b0;
         else        held[b] <= q[b];
      end
   end
endmodule

// File: rtl/olr_mode_dec.sv
module olr_mode_dec
   import olr_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  logic      ce_n,
   input  logic      oe_n,
   input  logic      vpp,
   input  logic      id_hv,
   output olr_mode_e mode,
   output logic      commit
);
   logic ce_n_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ce_n_q <= 1'b1;
      else        ce_n_q <= ce_n;
   end

   assign commit = vpp & oe_n & ce_n & ~ce_n_q;

   always_comb begin
      if (vpp) begin
         case ({ce_n, oe_n})
            2'b01:   mode = MD_PROGRAM;
            2'b10:   mode = MD_VERIFY;
            2'b11:   mode = MD_INHIBIT;
            default: mode = MD_OUT_OFF;
         endcase
      end else if (ce_n) begin
         mode = MD_STANDBY;
      end else if (oe_n) begin
         mode = MD_OUT_OFF;
      end else if (id_hv) begin
         mode = MD_IDENT;
      end else begin
         mode = MD_READ;
      end
   end
endmodule

// File: rtl/olr_cell_array.sv
module olr_cell_array #(
   parameter int AW = 11,
   parameter int DW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [AW-1:0] idx,
   input  logic          wr_en,
   input  logic [DW-1:0] wr_data,
   output logic [DW-1:0] rd_data
);
   localparam int DEPTH = 1 << AW;

   logic [DW-1:0] cells [DEPTH];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < DEPTH; i++) cells[i] <= '1;
      end else if (wr_en) begin
         cells[idx] <= cells[idx] & wr_data;
      end
   end

   assign rd_data = cells[idx];
endmodule

// File: rtl/otp_latched_rom.sv
module otp_latched_rom
   import olr_pkg::*;
#(
   parameter int ADDR_W   = 15,
   parameter int DATA_W   = 8,
   parameter int STORE_AW = 11
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic [DATA_W-1:0] din_i,
   output logic [DATA_W-1:0] dout_o,
   output logic              doe_o,
   input  logic              ce_n_i,
   input  logic              oe_n_i,
   input  logic              strb_i,
   input  logic              vpp_i,
   input  logic              id_hv_i
);
   if (STORE_AW > ADDR_W) begin : g_bad_store
      $error("STORE_AW must not exceed ADDR_W");
   end
   if (ADDR_W < 10) begin : g_bad_addr
      $error("ADDR_W must reach the identifier bit 9");
   end
   if (DATA_W != 8) begin : g_bad_data
      $error("identifier codes need DATA_W of 8");
   end

   logic [ADDR_W-1:0] addr_eff;
   logic [DATA_W-1:0] rd_data;
   logic [DATA_W-1:0] id_code;
   olr_mode_e         mode;
   logic              commit;

   olr_addr_latch #(.W(ADDR_W)) u_latch (
      .clk   (clk),
      .rst_n (rst_n),
      .pass  (strb_i | vpp_i),
      .d     (addr_i),
      .q     (addr_eff)
   );

   olr_mode_dec u_dec (
      .clk    (clk),
      .rst_n  (rst_n),
      .ce_n   (ce_n_i),
      .oe_n   (oe_n_i),
      .vpp    (vpp_i),
      .id_hv  (id_hv_i),
      .mode   (mode),
      .commit (commit)
   );

   olr_cell_array #(.AW(STORE_AW), .DW(DATA_W)) u_cells (
      .clk     (clk),
      .rst_n   (rst_n),
      .idx     (addr_eff[STORE_AW-1:0]),
      .wr_en   (commit),
      .wr_data (din_i),
      .rd_data (rd_data)
   );

   assign id_code = addr_i[0] ? ID_PART : ID_MAKER;

   always_comb begin
      case (mode)
         MD_READ, MD_VERIFY: begin doe_o = 1'b1; dout_o = rd_data; end
         MD_IDENT:           begin doe_o = 1'b1; dout_o = id_code; end
         default:            begin doe_o = 1'b0; dout_o = '0;      end
      endcase
   end
endmodule

// File: rtl/otp_latched_rom_chk.sv
module otp_latched_rom_chk #(
   parameter int ADDR_W = 15,
   parameter int DATA_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic [ADDR_W-1:0] addr_i,
   input logic [DATA_W-1:0] dout_o,
   input logic              doe_o,
   input logic              ce_n_i,
   input logic              oe_n_i,
   input logic              strb_i,
   input logic              vpp_i,
   input logic              id_hv_i,
   input logic [ADDR_W-1:0] addr_eff
);
   logic verify_now;
   assign verify_now = vpp_i & ce_n_i & ~oe_n_i;

   assert_standby_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (!vpp_i && ce_n_i) |-> !doe_o);

   assert_outoff_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (!vpp_i && !ce_n_i && oe_n_i) |-> !doe_o);

   assert_idle_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !doe_o |-> (dout_o == '0));

   assert_inhibit_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (vpp_i && (ce_n_i == oe_n_i)) |-> !doe_o);

   assert_hold_addr_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (!strb_i && !vpp_i) |=> ((!strb_i && !vpp_i) ? $stable(addr_eff) : 1'b1));

   assert_ident_code_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (id_hv_i && !vpp_i && !ce_n_i && !oe_n_i) |->
         (doe_o && dout_o == (addr_i[0] ? 8'h80 : 8'h20)));

   assert_no_regrow_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (verify_now && $past(verify_now) && addr_i == $past(addr_i)) |->
         ((dout_o & ~$past(dout_o)) == '0));
endmodule

bind otp_latched_rom otp_latched_rom_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .addr_i   (addr_i),
   .dout_o   (dout_o),
   .doe_o    (doe_o),
   .ce_n_i   (ce_n_i),
   .oe_n_i   (oe_n_i),
   .strb_i   (strb_i),
   .vpp_i    (vpp_i),
   .id_hv_i  (id_hv_i),
   .addr_eff (addr_eff)
);

// File: tb/otp_latched_rom_tb.sv
module otp_latched_rom_tb;
   localparam int AW = 15;
   localparam int SW = 11;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [AW-1:0] addr_i = '0;
   logic [7:0]    din_i = '0;
   logic [7:0]    dout_o;
   logic          doe_o;
   logic          ce_n_i = 1'b1, oe_n_i = 1'b1, strb_i = 1'b1, vpp_i = 1'b0, id_hv_i = 1'b0;

   logic [7:0] model [1 << SW];
   int checks = 0;
   int errors = 0;
   bit done = 0;

   always #2 clk = ~clk;

   otp_latched_rom #(.ADDR_W(AW), .DATA_W(8), .STORE_AW(SW)) u_dut (
      .clk(clk), .rst_n(rst_n), .addr_i(addr_i), .din_i(din_i), .dout_o(dout_o),
      .doe_o(doe_o), .ce_n_i(ce_n_i), .oe_n_i(oe_n_i), .strb_i(strb_i),
      .vpp_i(vpp_i), .id_hv_i(id_hv_i));

   function automatic logic [7:0] ref_at(input logic [AW-1:0] a);
      return model[a[SW-1:0]];
   endfunction

   function automatic logic [7:0] ident_of(input logic a0);
      return a0 ? 8'h80 : 8'h20;
   endfunction

   task automatic chk(input string req, input logic [8:0] got, input logic [8:0] exp);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s got=%h exp=%h at %0t", req, got, exp, $time);
      end
   endtask

   task automatic drive(input logic vpp, input logic strb, input logic ce_n, input logic oe_n,
                        input logic hv, input logic [AW-1:0] a, input logic [7:0] d);
      @(negedge clk);
      vpp_i = vpp; strb_i = strb; ce_n_i = ce_n; oe_n_i = oe_n; id_hv_i = hv;
      addr_i = a; din_i = d;
      #1;
   endtask

   task automatic idle();
      drive(1'b0, 1'b1, 1'b1, 1'b1, 1'b0, addr_i, 8'h00);
   endtask

   task automatic program_byte(input logic [AW-1:0] a, input logic [7:0] d);
      drive(1'b1, 1'b0, 1'b0, 1'b1, 1'b0, a, d);
      drive(1'b1, 1'b0, 1'b1, 1'b1, 1'b0, a, d);
      model[a[SW-1:0]] = model[a[SW-1:0]] & d;
      idle();
   endtask

   task automatic verify_byte(input string req, input logic [AW-1:0] a);
      drive(1'b1, 1'b0, 1'b1, 1'b0, 1'b0, a, 8'h00);
      chk(req, {doe_o, dout_o}, {1'b1, ref_at(a)});
      idle();
   endtask

   task automatic read_byte(input string req, input logic [AW-1:0] a);
      drive(1'b0, 1'b1, 1'b0, 1'b0, 1'b0, a, 8'h00);
      chk(req, {doe_o, dout_o}, {1'b1, ref_at(a)});
      idle();
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog expired got=running exp=finished");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      logic [AW-1:0] a, b;
      logic [7:0] d;
      void'($urandom(32'd20241));
      for (int i = 0; i < (1 << SW); i++) model[i] = 8'hFF;
      repeat (3) @(posedge clk);
      @(negedge clk) rst_n = 1'b1;

      // R1 reset state
      idle();
      chk("R1 standby undriven", {doe_o, dout_o}, 9'h000);
      read_byte("R1 erased cell", 15'h0005);
      read_byte("R1 erased top cell", 15'h7FFF);

      // R4 standby with oe low, output disable
      drive(1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 15'h0005, 8'h00);
      chk("R4 standby oe low", {doe_o, dout_o}, 9'h000);
      drive(1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 15'h0005, 8'h00);
      chk("R4 output disable", {doe_o, dout_o}, 9'h000);
      idle();

      // R5 program and AND semantics
      program_byte(15'h0012, 8'hA5);
      verify_byte("R5 first write", 15'h0012);
      program_byte(15'h0012, 8'h3C);
      verify_byte("R5 and with old", 15'h0012);
      read_byte("R7 R3 read after write", 15'h0012);

      // R2 latch holds while strobe low
      program_byte(15'h0033, 8'h0F);
      drive(1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 15'h0033, 8'h00);
      chk("R2 pass through", {doe_o, dout_o}, {1'b1, 8'h0F});
      drive(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 15'h0012, 8'h00);
      chk("R2 held after strobe low", {doe_o, dout_o}, {1'b1, 8'h0F});
      drive(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 15'h0044, 8'h00);
      chk("R2 still held", {doe_o, dout_o}, {1'b1, 8'h0F});
      drive(1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 15'h0012, 8'h00);
      chk("R2 reopened", {doe_o, dout_o}, {1'b1, ref_at(15'h0012)});

      // R9 identifier with strobe low
      drive(1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 15'h0000, 8'h00);
      chk("R9 maker code", {doe_o, dout_o}, {1'b1, ident_of(1'b0)});
      drive(1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 15'h0001, 8'h00);
      chk("R9 part code", {doe_o, dout_o}, {1'b1, ident_of(1'b1)});
      idle();

      // R6 rising enable without supply flag
      drive(1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 15'h0055, 8'h00);
      drive(1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 15'h0055, 8'h00);
      idle();
      verify_byte("R6 no write without supply", 15'h0055);
      // R8 both enables low under supply, then R6 rising with oe low
      drive(1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 15'h0055, 8'h00);
      chk("R8 both low undriven", {doe_o, dout_o}, 9'h000);
      drive(1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 15'h0055, 8'h00);
      chk("R6 no write with oe low", {doe_o, dout_o}, {1'b1, 8'hFF});
      idle();
      drive(1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 15'h0055, 8'h00);
      chk("R8 inhibit undriven", {doe_o, dout_o}, 9'h000);
      idle();
      verify_byte("R8 inhibit wrote nothing", 15'h0055);

      // R10 aliasing
      program_byte(15'h4066, 8'h81);
      read_byte("R10 alias low", 15'h0066);
      read_byte("R10 alias other", 15'h2866);

      // random mix
      for (int n = 0; n < 400; n++) begin
         a = AW'($urandom % 16) | AW'(($urandom % 16) << SW);
         d = 8'($urandom);
         case ($urandom % 4)
            0: program_byte(a, d);
            1: verify_byte("R7 R11 random verify", a);
            2: read_byte("R3 R10 random read", a);
            default: begin
               b = AW'($urandom % 16);
               drive(1'b0, 1'b1, 1'b0, 1'b0, 1'b0, a, 8'h00);
               drive(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, b, 8'h00);
               chk("R2 random hold", {doe_o, dout_o}, {1'b1, ref_at(a)});
               idle();
            end
         endcase
      end

      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule